// File: doc/BRIEF.md
# Down-Counting PWM DAC Generator with Shadowed Duty

The block drives a single pulse-width-modulated pin whose average level stands for an N-bit sample, so that an external low-pass network can turn it into an analog voltage. A timer of N bits counts down from its top value to zero, giving a period of 2^N clock cycles. The pin is high while the count is below the active compare value. The high stretch therefore sits at the end of each period, and every period ends with a falling edge at the wrap.

A producer writes new duty values at any time. Each write lands in a shadow register, and the active compare value takes the shadow only in the cycle where the count is zero. The output period in progress is never disturbed. A one-cycle pulse fires when the falling count meets the active compare value. It tells the producer that the next sample may be written before the coming wrap. A small on-chip sample table can feed the shadow instead: on each such pulse it hands over its next entry and wraps at a programmed length.

A two-state run controller sets the pace of the counter. From reset it sits in ST_HALT. The transition HALT_TO_RUN is taken on the clock edge that samples `en` high. The transition RUN_TO_HALT is taken on the edge that samples `en` low. In all other cases each state holds. The counter advances only while the controller is in ST_RUN.

Top module: `pwmdac_gen`

## Requirements
- R1: While the controller is in ST_RUN, `zero_evt` is high for exactly one cycle in every 2^N cycles, namely the cycle in which the count is zero.
- R2: The count moves down by one each running cycle and reloads to 2^N-1 on the cycle after zero. For an active compare value C, `cmp_evt` therefore falls in cycle 2^N-1-C of a period, counting the reload cycle as cycle 0.
- R3: In each running period, `pwm_out` is high for exactly C cycles. C = 0 gives a constant low, and C = 2^N-1 gives high for all but one cycle.
- R4: A duty write is held in the shadow and becomes active only at the next zero cycle. A write captured on the edge that ends a zero cycle waits for the following zero cycle, so the period in progress always keeps its duty.
- R5: `cmp_evt` is a single-cycle pulse, issued once per running period in the cycle where the count equals the active compare value.
- R6: Duty and table writes keep only the low N bits of their data word.
- R7: With `tbl_mode` high, every `cmp_evt` copies table entry [index] into the shadow and advances the index. The index returns to 0 once index+1 reaches the programmed length or the last table slot. The length register resets to the table depth.
- R8: If a duty write and a table transfer fall in the same cycle, the duty write sets the shadow, and the table index still advances.
- R9: A synchronous active-high `rst` clears the count, shadow, active compare and table index. It also puts the controller in ST_HALT, so `pwm_out`, `cmp_evt` and `zero_evt` are low during reset and the first period after it has C = 0.
- R10: In ST_HALT the count is frozen and all three outputs are low. Duty writes still reach the shadow, and the count resumes from where it stopped.
- R11: In a running period the output is low in the reload cycle and, for C > 0, high in the zero cycle, so the falling edge lies on the period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request for the controller |
| duty_we | input | 1 | Duty write strobe into the shadow |
| duty_wdata | input | WR_W | Duty word; low RES_BITS bits are used |
| tbl_mode | input | 1 | Feed the shadow from the sample table |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_waddr | input | $clog2(TBL_DEPTH) | Table entry address |
| tbl_wdata | input | WR_W | Table entry word; low RES_BITS bits are used |
| len_we | input | 1 | Table length write strobe |
| len_wdata | input | $clog2(TBL_DEPTH)+1 | Number of table entries in the cycle |
| pwm_out | output | 1 | PWM output |
| cmp_evt | output | 1 | Compare-down event pulse |
| zero_evt | output | 1 | Zero event pulse |

## Verification
The bench builds the block with RES_BITS = 4, TBL_DEPTH = 8 and WR_W = 8. A 16-cycle period lets every cycle of a period be sampled and the whole duty range be swept, including both extremes. An 8-bit data word with a 4-bit resolution exposes truncation. A short table makes it practical to run through several wraps at a length of 3. Writes are placed on chosen cycles of a period, including the compare-event cycle and the zero cycle, to test the commit timing and the write priority.

// File: rtl/pwmdac_pkg.sv
package pwmdac_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Run controller states
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/pwmdac_ctrl.sv
module pwmdac_ctrl
    import pwmdac_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [RES_BITS-1:0] cnt_o,
    output logic                run_o,
    output logic                zero_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [RES_BITS-1:0] CNT_TOP = '1;

    run_state_t          state_q;
    run_state_t          state_d;
    logic [RES_BITS-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (en)  state_d = ST_RUN;   // HALT_TO_RUN
            ST_RUN:  if (!en) state_d = ST_HALT;  // RUN_TO_HALT
            default: state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALT;
        else     state_q <= state_d;
    end

    // down counter, advancing only while running
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (cnt_q == '0) cnt_q <= CNT_TOP;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        run_o  = (state_q == ST_RUN);
        zero_o = (state_q == ST_RUN) && (cnt_q == '0);
        cnt_o  = cnt_q;
    end

    assert_reload_R2: assert property (@(posedge clk) disable iff (rst)
        (run_o && cnt_q == '0) |=> (cnt_q == CNT_TOP));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run_o && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        (!run_o) |=> $stable(cnt_q));

    assert_zero_single_R1: assert property (@(posedge clk) disable iff (rst)
        zero_o |=> !zero_o);
endmodule

// File: rtl/pwmdac_cmp.sv
module pwmdac_cmp #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic                zero_i,
    input  logic [RES_BITS-1:0] cnt_i,
    input  logic                load_en,
    input  logic [RES_BITS-1:0] load_val,
    output logic                pwm_o,
    output logic                match_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [RES_BITS-1:0] shadow_q;
    logic [RES_BITS-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst)          shadow_q <= '0;
        else if (load_en) shadow_q <= load_val;
    end

    // commit at the zero cycle; takes the shadow as it stood before this edge
    always_ff @(posedge clk) begin
        if (rst)         active_q <= '0;
        else if (zero_i) active_q <= shadow_q;
    end

    always_comb begin
        pwm_o   = run_i && (cnt_i < active_q);
        match_o = run_i && (cnt_i == active_q);
    end

    assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(zero_i));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (match_o && !zero_i) |=> !match_o);

    assert_fall_at_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwm_o) && run_i) |-> $past(zero_i));
endmodule

// File: rtl/pwmdac_table.sv
module pwmdac_table #(
    parameter int RES_BITS  = 10,
    parameter int TBL_DEPTH = 64,
    parameter int WR_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          mode_i,
    input  logic                          step_i,
    input  logic                          wr_en,
    input  logic [$clog2(TBL_DEPTH)-1:0]  wr_addr,
    input  logic [WR_W-1:0]               wr_data,
    input  logic                          len_en,
    input  logic [$clog2(TBL_DEPTH):0]    len_data,
    output logic [RES_BITS-1:0]           entry_o,
    output logic                          entry_vld
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = $clog2(TBL_DEPTH);
    localparam int LW = AW + 1;
    localparam logic [AW-1:0] LAST_SLOT = AW'(TBL_DEPTH - 1);

    logic [RES_BITS-1:0] mem_q [TBL_DEPTH];
    logic [LW-1:0]       len_q;
    logic [AW-1:0]       idx_q;
    logic [LW-1:0]       idx_nxt;
    logic                wrap;
    logic                advance;

    generate
        if (WR_W > RES_BITS) begin : g_sink
            logic unused_hi;
            assign unused_hi = ^wr_data[WR_W-1:RES_BITS];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_addr} < LW'(TBL_DEPTH)))
            mem_q[wr_addr] <= wr_data[RES_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         len_q <= LW'(TBL_DEPTH);
        else if (len_en) len_q <= len_data;
    end

    always_comb begin
        advance = mode_i && step_i;
        idx_nxt = {1'b0, idx_q} + LW'(1);
        wrap    = (idx_nxt >= len_q) || (idx_q == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst)          idx_q <= '0;
        else if (advance) idx_q <= wrap ? '0 : idx_nxt[AW-1:0];
    end

    always_comb begin
        entry_o   = mem_q[idx_q];
        entry_vld = advance;
    end

    assert_idx_range_R7: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, idx_q} < LW'(TBL_DEPTH)));

    assert_idx_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(mode_i && step_i) |=> $stable(idx_q));
endmodule

// File: rtl/pwmdac_gen.sv
module pwmdac_gen #(
    parameter int RES_BITS  = 10,
    parameter int TBL_DEPTH = 64,
    parameter int WR_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          duty_we,
    input  logic [WR_W-1:0]               duty_wdata,
    input  logic                          tbl_mode,
    input  logic                          tbl_we,
    input  logic [$clog2(TBL_DEPTH)-1:0]  tbl_waddr,
    input  logic [WR_W-1:0]               tbl_wdata,
    input  logic                          len_we,
    input  logic [$clog2(TBL_DEPTH):0]    len_wdata,
    output logic                          pwm_out,
    output logic                          cmp_evt,
    output logic                          zero_evt
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [RES_BITS-1:0] cnt;
    logic                run;
    logic                zero_hit;
    logic                match;
    logic [RES_BITS-1:0] tbl_entry;
    logic                tbl_vld;
    logic                load_en;
    logic [RES_BITS-1:0] load_val;

    generate
        if (WR_W > RES_BITS) begin : g_sink
            logic unused_hi;
            assign unused_hi = ^duty_wdata[WR_W-1:RES_BITS];
        end
    endgenerate

    // duty write takes priority over a table transfer
    always_comb begin
        load_en  = duty_we || tbl_vld;
        load_val = duty_we ? duty_wdata[RES_BITS-1:0] : tbl_entry;
    end

    pwmdac_ctrl #(.RES_BITS(RES_BITS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt_o  (cnt),
        .run_o  (run),
        .zero_o (zero_hit)
    );

    pwmdac_cmp #(.RES_BITS(RES_BITS)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .zero_i   (zero_hit),
        .cnt_i    (cnt),
        .load_en  (load_en),
        .load_val (load_val),
        .pwm_o    (pwm_out),
        .match_o  (match)
    );

    pwmdac_table #(
        .RES_BITS  (RES_BITS),
        .TBL_DEPTH (TBL_DEPTH),
        .WR_W      (WR_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (tbl_mode),
        .step_i    (match),
        .wr_en     (tbl_we),
        .wr_addr   (tbl_waddr),
        .wr_data   (tbl_wdata),
        .len_en    (len_we),
        .len_data  (len_wdata),
        .entry_o   (tbl_entry),
        .entry_vld (tbl_vld)
    );

    always_comb begin
        cmp_evt  = match;
        zero_evt = zero_hit;
    end
endmodule

// File: tb/pwmdac_gen_bench.sv
module pwmdac_gen_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NB  = 4;
    localparam int DEP = 8;
    localparam int WW  = 8;
    localparam int AW  = 3;
    localparam int P   = 16;

    localparam logic [7:0] VEC [6] = '{8'h00, 8'h01, 8'h07, 8'h0F, 8'h0E, 8'h35};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic          duty_we = 1'b0;
    logic [WW-1:0] duty_wdata = '0;
    logic          tbl_mode = 1'b0;
    logic          tbl_we = 1'b0;
    logic [AW-1:0] tbl_waddr = '0;
    logic [WW-1:0] tbl_wdata = '0;
    logic          len_we = 1'b0;
    logic [AW:0]   len_wdata = '0;
    logic          pwm_out;
    logic          cmp_evt;
    logic          zero_evt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pwmdac_gen #(.RES_BITS(NB), .TBL_DEPTH(DEP), .WR_W(WW)) u_pwmdac_gen (
        .clk(clk), .rst(rst), .en(en),
        .duty_we(duty_we), .duty_wdata(duty_wdata),
        .tbl_mode(tbl_mode), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .len_we(len_we), .len_wdata(len_wdata),
        .pwm_out(pwm_out), .cmp_evt(cmp_evt), .zero_evt(zero_evt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_duty(input logic [7:0] v);
        @(negedge clk); duty_we = 1'b1; duty_wdata = v;
        @(negedge clk); duty_we = 1'b0;
    endtask

    task automatic wr_tbl(input int a, input logic [7:0] v);
        @(negedge clk); tbl_we = 1'b1; tbl_waddr = AW'(a); tbl_wdata = v;
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic sync_zero();
        int g = 0;
        @(negedge clk);
        while (!zero_evt && g < 200) begin
            @(negedge clk);
            g++;
        end
    endtask

    // samples one full period starting at the reload cycle; optional duty write at wr_idx
    task automatic measure(input int wr_idx, input logic [7:0] wr_val,
                           output int highs, output int evts, output int epos,
                           output int zeros, output int zpos,
                           output int first_hi, output int last_hi);
        highs = 0; evts = 0; epos = -1; zeros = 0; zpos = -1; first_hi = 0; last_hi = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (cmp_evt) begin evts++; epos = k; end
            if (zero_evt) begin zeros++; zpos = k; end
            if (k == 0) first_hi = int'(pwm_out);
            if (k == P - 1) last_hi = int'(pwm_out);
            duty_we = (k == wr_idx);
            duty_wdata = wr_val;
        end
    endtask

    initial begin
        int h, e, ep, z, zp, fh, lh;
        int bad_cnt;
        int c;
        int exp_tbl [5];

        // R9: outputs low during reset
        repeat (3) @(negedge clk);
        chk("R9 pwm in reset", int'(pwm_out), 0);
        chk("R9 cmp_evt in reset", int'(cmp_evt), 0);
        chk("R9 zero_evt in reset", int'(zero_evt), 0);
        en = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        sync_zero();
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R9 first period duty zero", h, 0);
        chk("R5 event at zero for C=0", ep, P - 1);

        // vector sweep: R1 R2 R3 R5 R6 R11
        for (int i = 0; i < 6; i++) begin
            c = int'(VEC[i][3:0]);
            wr_duty(VEC[i]);
            sync_zero();
            measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
            chk("R3 R6 high cycles", h, c);
            chk("R5 one event", e, 1);
            chk("R2 event position", ep, P - 1 - c);
            chk("R1 one zero event", z, 1);
            chk("R1 zero at period end", zp, P - 1);
            chk("R11 low at reload", fh, 0);
            chk("R11 high at zero", lh, (c != 0) ? 1 : 0);
        end

        // R4: mid-period write, then write in the zero cycle
        wr_duty(8'h06);
        sync_zero();
        measure(5, 8'h0A, h, e, ep, z, zp, fh, lh);
        chk("R4 mid write keeps period", h, 6);
        measure(P - 1, 8'h03, h, e, ep, z, zp, fh, lh);
        chk("R4 mid write next period", h, 10);
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R4 zero-cycle write waits", h, 10);
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R4 zero-cycle write lands", h, 3);

        // R10: freeze, shadow write while frozen, resume
        en = 1'b0;
        bad_cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k > 0 && (pwm_out || cmp_evt || zero_evt)) bad_cnt++;
            duty_we = (k == 5);
            duty_wdata = 8'h08;
        end
        chk("R10 outputs low while halted", bad_cnt, 0);
        en = 1'b1;
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R10 resume keeps old duty", h, 3);
        chk("R10 count resumed from top", zp, P - 1);
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R10 frozen write applied", h, 8);

        // R7: table playback with length 3
        wr_tbl(0, 8'h09);
        wr_tbl(1, 8'hF4);
        wr_tbl(2, 8'h0C);
        for (int a = 3; a < DEP; a++) wr_tbl(a, 8'h01);
        @(negedge clk); len_we = 1'b1; len_wdata = 4'd3;
        @(negedge clk); len_we = 1'b0;
        wr_duty(8'h05);
        sync_zero();
        tbl_mode = 1'b1;
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R7 period before table", h, 5);
        exp_tbl = '{9, 4, 12, 9, 4};
        for (int p = 0; p < 4; p++) begin
            measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
            chk("R7 R6 table entry", h, exp_tbl[p]);
        end
        // R8: duty write in the event cycle of a period with C=4
        measure(P - 1 - 4, 8'h07, h, e, ep, z, zp, fh, lh);
        chk("R7 table wrap entry", h, exp_tbl[4]);
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R8 duty write wins", h, 7);
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R8 index still advanced", h, 9);
        tbl_mode = 1'b0;

        // R9: reset while running
        wr_duty(8'h0B);
        sync_zero();
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R3 before reset", h, 11);
        rst = 1'b1;
        bad_cnt = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (pwm_out || cmp_evt || zero_evt) bad_cnt++;
        end
        chk("R9 outputs low in run reset", bad_cnt, 0);
        rst = 1'b0;
        sync_zero();
        measure(-1, 8'h00, h, e, ep, z, zp, fh, lh);
        chk("R9 duty cleared by reset", h, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule